// File: doc/BRIEF.md
# Clock Crosspoint and Post-Divider Bank

This block turns four clock sources into six clock outputs. The sources are a reference and three PLL outputs, and they arrive on `src_in`. A crosspoint lets each of four general outputs pick any one of the sources. Each general output then has a 7-bit programmable divider. A fifth output is fed only from PLL1, through a small post-divider that can divide by 2, 3 or 4. A sixth output is a buffered copy of the reference. All configuration arrives on static register inputs. Each output can be disabled, and a disabled output reports a high-impedance flag.

The sources are modelled as plain clocks. A fast core clock `clk` samples them, and every output is produced in the `clk` domain. Each divider is a small state machine with four states:
- `DV_OFF`: the output is held low. The divider is in this state after reset and whenever its divide value is 0.
- `DV_PASS`: the source goes straight through. This is the state for a divide value of 1.
- `DV_HIGH`: the high phase of a divided period.
- `DV_LOW`: the low phase of a divided period.

The transitions are:
- Any state goes to `DV_OFF` when the divide value is 0.
- Any state goes to `DV_PASS` when the divide value is 1.
- When the divide value is 2 or more, `DV_OFF` or `DV_PASS` goes to `DV_HIGH` on the next source rising edge.
- `DV_HIGH` goes to `DV_LOW` after floor(N/2) source rising edges.
- `DV_LOW` goes to `DV_HIGH` after the remaining N − floor(N/2) source rising edges.

Top module: `clkx_bank`

## Requirements
- R1: For each general output k, `route_sel[2k+1:2k]` selects its source: 0 = reference (`src_in[0]`), 1 = PLL1 (`src_in[1]`), 2 = PLL2 (`src_in[2]`), 3 = PLL3 (`src_in[3]`).
- R2: With a divide value N ≥ 2 on `div_val[7k+6:7k]`, output k has a period of N source periods. It is high for floor(N/2) source periods, which gives a 50% duty cycle for even N.
- R3: With a divide value of 1, the output is a copy of the selected source, delayed by one `clk` cycle.
- R4: With a divide value of 0, the output stays low.
- R5: `clk_e` divides PLL1. `e_div_sel` code 0 divides by 2, code 1 divides by 3, and codes 2 and 3 divide by 4. The high time follows the same floor(N/2) rule as R2.
- R6: `clk_ref` is the reference delayed by one `clk` cycle, with no division.
- R7: An `out_en` bit at 0 sets the matching `hiz` bit to 1 and drives that output low. The bit mapping is: bits 0–3 are outputs A–D, bit 4 is `clk_e`, and bit 5 is `clk_ref`. The divider behind a disabled output keeps counting, and its output resumes correct periods when it is enabled again.
- R8: While reset is active, and in the first cycle after it is released, all clock outputs are low.
- R9: The full divide range is reachable: a divide value of 127 gives a period of 127 source periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core sampling clock, faster than every source |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 4 | Sources: bit 0 reference, bits 1–3 PLL1–PLL3 |
| route_sel | input | 8 | Source select, 2 bits per general output |
| div_val | input | 28 | Divide value, 7 bits per general output |
| e_div_sel | input | 2 | Post-divider code for the PLL1 output |
| out_en | input | 6 | Per-output enable: A–D, E, reference buffer |
| clk_out | output | 4 | Divided general outputs A–D |
| clk_e | output | 1 | Divided PLL1 output |
| clk_ref | output | 1 | Buffered reference |
| hiz | output | 6 | High-impedance flag for each output |

## Verification
The bench builds the block with its default parameters: four sources, four general outputs and 7-bit divide values. With these values every select code and the largest divide value, 127, can be tested. The bench drives the four sources with distinct periods of 4, 6, 2 and 10 core cycles. Because the periods differ, a wrong route shows up as a wrong measured period. The fastest source makes a divide-by-127 period only 254 cycles long. Odd divide values, such as 3 and 5, show the floor(N/2) high time separately from the even case.

// File: rtl/clkx_pkg.sv
`timescale 1ns/1ps
package clkx_pkg;
    typedef enum logic [1:0] {
        DV_OFF  = 2'd0,
        DV_PASS = 2'd1,
        DV_HIGH = 2'd2,
        DV_LOW  = 2'd3
    } dv_state_t;

    localparam int E_CODE_W = 2;
endpackage

// File: rtl/clkx_xbar.sv
`timescale 1ns/1ps
module clkx_xbar #(
    parameter  int NUM_SRC = 4,
    parameter  int NUM_OUT = 4,
    localparam int SEL_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]       src_i,
    input  logic [NUM_OUT*SEL_W-1:0] sel_i,
    output logic [NUM_OUT-1:0]       routed_o
);
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_route
        assign routed_o[g] = src_i[sel_i[g*SEL_W +: SEL_W]];
    end
endmodule

// File: rtl/clkx_divider.sv
`timescale 1ns/1ps
module clkx_divider
    import clkx_pkg::*;
#(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    dv_state_t        state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [DIV_W-1:0] hi_len, lo_len, cnt_inc;
    logic             src_q;
    logic             rise;

    assign hi_len  = div_i >> 1;
    assign lo_len  = div_i - hi_len;
    assign cnt_inc = cnt_q + DIV_W'(1);
    assign rise    = src_i & ~src_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DV_OFF;
            cnt_q   <= '0;
            src_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            src_q   <= src_i;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (div_i == '0) begin
            state_d = DV_OFF;
            cnt_d   = '0;
        end else if (div_i == DIV_W'(1)) begin
            state_d = DV_PASS;
            cnt_d   = '0;
        end else if (rise) begin
            unique case (state_q)
                DV_OFF, DV_PASS: begin
                    state_d = DV_HIGH;
                    cnt_d   = '0;
                end
                DV_HIGH: begin
                    if (cnt_inc >= hi_len) begin
                        state_d = DV_LOW;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
                DV_LOW: begin
                    if (cnt_inc >= lo_len) begin
                        state_d = DV_HIGH;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            DV_OFF:  tick_o = 1'b0;
            DV_PASS: tick_o = src_q;
            DV_HIGH: tick_o = 1'b1;
            DV_LOW:  tick_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/clkx_bank.sv
`timescale 1ns/1ps
module clkx_bank
    import clkx_pkg::*;
#(
    parameter  int NUM_SRC = 4,
    parameter  int NUM_OUT = 4,
    parameter  int DIV_W   = 7,
    localparam int SEL_W   = $clog2(NUM_SRC),
    localparam int EN_W    = NUM_OUT + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_in,
    input  logic [NUM_OUT*SEL_W-1:0] route_sel,
    input  logic [NUM_OUT*DIV_W-1:0] div_val,
    input  logic [E_CODE_W-1:0]      e_div_sel,
    input  logic [EN_W-1:0]          out_en,
    output logic [NUM_OUT-1:0]       clk_out,
    output logic                     clk_e,
    output logic                     clk_ref,
    output logic [EN_W-1:0]          hiz
);
    localparam int E_IDX   = NUM_OUT;
    localparam int REF_IDX = NUM_OUT + 1;

    logic [NUM_OUT-1:0] routed;
    logic [NUM_OUT-1:0] tick;
    logic [DIV_W-1:0]   e_div;
    logic               e_tick;
    logic               ref_q;

    clkx_xbar #(
        .NUM_SRC (NUM_SRC),
        .NUM_OUT (NUM_OUT)
    ) u_xbar (
        .src_i    (src_in),
        .sel_i    (route_sel),
        .routed_o (routed)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_div
        clkx_divider #(
            .DIV_W (DIV_W)
        ) u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (routed[g]),
            .div_i  (div_val[g*DIV_W +: DIV_W]),
            .tick_o (tick[g])
        );
        assign clk_out[g] = out_en[g] & tick[g];
    end

    always_comb begin
        unique case (e_div_sel)
            2'd0:    e_div = DIV_W'(2);
            2'd1:    e_div = DIV_W'(3);
            default: e_div = DIV_W'(4);
        endcase
    end

    clkx_divider #(
        .DIV_W (DIV_W)
    ) u_ediv (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_in[1]),
        .div_i  (e_div),
        .tick_o (e_tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_q <= 1'b0;
        else        ref_q <= src_in[0];
    end

    assign clk_e   = out_en[E_IDX] & e_tick;
    assign clk_ref = out_en[REF_IDX] & ref_q;
    assign hiz     = ~out_en;
endmodule

// File: rtl/clkx_bank_chk.sv
`timescale 1ns/1ps
module clkx_bank_chk #(
    parameter  int NUM_SRC = 4,
    parameter  int NUM_OUT = 4,
    parameter  int DIV_W   = 7,
    localparam int SEL_W   = $clog2(NUM_SRC),
    localparam int EN_W    = NUM_OUT + 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_SRC-1:0]       src_in,
    input logic [NUM_OUT*SEL_W-1:0] route_sel,
    input logic [NUM_OUT*DIV_W-1:0] div_val,
    input logic [NUM_OUT-1:0]       clk_out,
    input logic                     clk_e,
    input logic                     clk_ref,
    input logic [EN_W-1:0]          out_en,
    input logic [EN_W-1:0]          hiz
);
    // R8
    rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (clk_out == '0 && !clk_e && !clk_ref));

    // R6
    ref_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_en[NUM_OUT+1]) |-> clk_ref == $past(src_in[0]));

    for (genvar k = 0; k < EN_W; k++) begin : g_en
        // R7
        hiz_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !out_en[k] |-> hiz[k]);
    end

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        // R7
        hiz_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !out_en[k] |-> !clk_out[k]);

        // R4
        div0_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (div_val[k*DIV_W +: DIV_W] == '0 && $past(div_val[k*DIV_W +: DIV_W]) == '0)
            |-> !clk_out[k]);

        // R3
        pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && out_en[k]
             && div_val[k*DIV_W +: DIV_W] == DIV_W'(1)
             && $past(div_val[k*DIV_W +: DIV_W]) == DIV_W'(1)
             && $stable(route_sel[k*SEL_W +: SEL_W]))
            |-> clk_out[k] == $past(src_in[route_sel[k*SEL_W +: SEL_W]]));
    end
endmodule

bind clkx_bank clkx_bank_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_OUT (NUM_OUT),
    .DIV_W   (DIV_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_in    (src_in),
    .route_sel (route_sel),
    .div_val   (div_val),
    .clk_out   (clk_out),
    .clk_e     (clk_e),
    .clk_ref   (clk_ref),
    .out_en    (out_en),
    .hiz       (hiz)
);

// File: tb/sim_clkx_bank.sv
`timescale 1ns/1ps
module sim_clkx_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_in = '0;
    logic [7:0]  route_sel = '0;
    logic [27:0] div_val = '0;
    logic [1:0]  e_div_sel = '0;
    logic [5:0]  out_en = '1;
    logic [3:0]  clk_out;
    logic        clk_e;
    logic        clk_ref;
    logic [5:0]  hiz;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    clkx_bank u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .route_sel (route_sel),
        .div_val   (div_val),
        .e_div_sel (e_div_sel),
        .out_en    (out_en),
        .clk_out   (clk_out),
        .clk_e     (clk_e),
        .clk_ref   (clk_ref),
        .hiz       (hiz)
    );

    // source periods in clk cycles: ref 4, pll1 6, pll2 2, pll3 10
    initial begin
        int ph [4];
        int per [4];
        per = '{4, 6, 2, 10};
        ph  = '{0, 0, 0, 0};
        forever begin
            @(negedge clk);
            for (int s = 0; s < 4; s++) begin
                ph[s] = (ph[s] + 1) % per[s];
                src_in[s] = (ph[s] < per[s] / 2);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic sig(input int which);
        if (which < 4)  return clk_out[which];
        if (which == 4) return clk_e;
        return clk_ref;
    endfunction

    task automatic wait_rise(input int which, output bit ok);
        logic prev;
        ok = 0;
        prev = sig(which);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!prev && sig(which)) begin
                ok = 1;
                return;
            end
            prev = sig(which);
        end
    endtask

    // second full period after the call: high cycles and total cycles
    task automatic measure(input int which, output int per, output int hi);
        bit ok;
        per = -1;
        hi  = -1;
        wait_rise(which, ok);
        if (!ok) return;
        wait_rise(which, ok);
        if (!ok) return;
        hi = 0;
        while (sig(which) && hi < 2000) begin
            hi++;
            @(negedge clk);
        end
        per = hi;
        while (!sig(which) && per < 4000) begin
            per++;
            @(negedge clk);
        end
    endtask

    task automatic set_out(input int k, input int sel, input int n);
        @(negedge clk);
        route_sel[k*2 +: 2] = sel[1:0];
        div_val[k*7 +: 7]   = n[6:0];
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R8 clk_out in reset", int'(clk_out), 0);
        check("R8 clk_e in reset", int'(clk_e), 0);
        check("R8 clk_ref in reset", int'(clk_ref), 0);
    endtask

    task automatic t_route();
        int p, h;
        set_out(0, 0, 2);
        set_out(1, 1, 5);
        set_out(2, 2, 127);
        set_out(3, 3, 3);
        measure(0, p, h);
        check("R1 R2 A ref/2 period", p, 8);
        check("R2 A ref/2 high", h, 4);
        measure(1, p, h);
        check("R1 R2 B pll1/5 period", p, 30);
        check("R2 B pll1/5 high", h, 12);
        measure(2, p, h);
        check("R9 R1 C pll2/127 period", p, 254);
        check("R9 C pll2/127 high", h, 126);
        measure(3, p, h);
        check("R1 R2 D pll3/3 period", p, 30);
        check("R2 D pll3/3 high", h, 10);
    endtask

    task automatic t_pass();
        int p, h;
        set_out(0, 3, 1);
        set_out(1, 0, 1);
        measure(0, p, h);
        check("R3 A pll3 pass period", p, 10);
        check("R3 A pll3 pass high", h, 5);
        measure(1, p, h);
        check("R3 B ref pass period", p, 4);
        check("R3 B ref pass high", h, 2);
    endtask

    task automatic t_zero();
        int highs;
        set_out(3, 3, 0);
        highs = 0;
        repeat (60) begin
            @(negedge clk);
            if (clk_out[3]) highs++;
        end
        check("R4 D div0 high samples", highs, 0);
    endtask

    task automatic t_epost();
        int p, h;
        int ep [4] = '{12, 18, 24, 24};
        int eh [4] = '{6, 6, 12, 12};
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            e_div_sel = c[1:0];
            measure(4, p, h);
            check($sformatf("R5 E code %0d period", c), p, ep[c]);
            check($sformatf("R5 E code %0d high", c), h, eh[c]);
        end
    endtask

    task automatic t_refbuf();
        int p, h;
        measure(5, p, h);
        check("R6 ref buffer period", p, 4);
        check("R6 ref buffer high", h, 2);
    endtask

    task automatic t_oe();
        int highs, p, h;
        set_out(3, 3, 3);
        @(negedge clk);
        out_en = 6'b000111;
        highs = 0;
        repeat (60) begin
            @(negedge clk);
            if (clk_out[3] || clk_e || clk_ref) highs++;
        end
        check("R7 disabled outputs high samples", highs, 0);
        check("R7 hiz flags", int'(hiz), 6'b111000);
        @(negedge clk);
        out_en = '1;
        @(negedge clk);
        check("R7 hiz cleared", int'(hiz), 0);
        measure(3, p, h);
        check("R7 D resumes period", p, 30);
        check("R7 D resumes high", h, 10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_route();
        t_pass();
        t_zero();
        t_epost();
        t_refbuf();
        t_oe();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule